// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block applies the architectural state changes that a processor core makes when it takes a normal interrupt, and reverses them when it returns from one. It holds the program counter, the status word, the saved copy of the status word used by interrupt mode and the interrupt-mode link register. A pending request is considered only when the pipeline marks an instruction boundary and the status word does not mask it. When the request is accepted, every change lands on a single clock edge and a one-cycle taken strobe tells the pipeline to flush and fetch from the vector.

The status word keeps its mode in bits 4:0, the instruction-set state in bit 5, the fast-interrupt mask in bit 6 and the normal interrupt mask in bit 7. Entry copies the whole status word to the saved copy, switches the mode to interrupt mode (5'b10010), sets both mask bits, selects the full-width instruction set by clearing bit 5, stores the old program counter in the link register and loads the program counter with the vector. A return command given while a handler is running restores the status word from the saved copy and loads the program counter from a supplied address. Outside these two events the pipeline writes the status word and the program counter through plain write ports.

There are two states. THREAD is normal execution. HANDLER means an interrupt is being serviced. The ENTER transition goes from THREAD to HANDLER. The NEST transition goes from HANDLER back to HANDLER when the handler has cleared its own mask and a second request arrives. The RETURN transition goes from HANDLER to THREAD on a return command.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the status word is 0x000000D3 (supervisor mode 5'b10011, bits 7 and 6 set, bit 5 clear). The program counter, saved status and link register are 0, the taken strobe is low and the handler flag is low.
- R2: A request is accepted at a clock edge exactly when irq_req and insn_boundary are high, bit 7 of the status word is 0 and no return is taking effect. taken_o is high for the one cycle after that edge and low in the following cycle.
- R3: On acceptance the saved status takes the status word as it was before the edge.
- R4: On acceptance the status word becomes its old bits 31:8, then bit 7 = 1, bit 6 = 1, bit 5 = 0 and mode 5'b10010.
- R5: On acceptance the link register takes the old program counter and the program counter becomes 0x00000018.
- R6: When bit 7 of the status word is set or insn_boundary is low, a request changes no state and raises no strobe.
- R7: A return command while the handler flag is high copies the saved status into the status word, loads the program counter from eret_addr and clears the handler flag, all on one edge.
- R8: A return command while the handler flag is low has no effect on any state.
- R9: If a return and an otherwise acceptable request arrive together, the return is performed and the request is not accepted in that cycle.
- R10: The status and program-counter write ports take effect when neither entry nor return happens, and entry or return overrides them in the same cycle.
- R11: With the handler flag high and bit 7 cleared by a status write, a new request is accepted (NEST). The saved status then takes the handler's status word, and the handler flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Level interrupt request from the external controller |
| insn_boundary | input | 1 | High when the pipeline is at an instruction boundary |
| eret_cmd | input | 1 | Exception-return command |
| eret_addr | input | XLEN | Return address used by the return command |
| stat_we | input | 1 | Status word write enable |
| stat_wdata | input | XLEN | Status word write data |
| pc_we | input | 1 | Program counter write enable |
| pc_wdata | input | XLEN | Program counter write data |
| status_o | output | XLEN | Current status word |
| saved_status_o | output | XLEN | Interrupt-mode saved status |
| link_o | output | XLEN | Interrupt-mode link register |
| pc_o | output | XLEN | Program counter |
| taken_o | output | 1 | One-cycle strobe after an accepted interrupt |
| handler_active_o | output | 1 | High in the HANDLER state |

## Verification
Every result is registered: status word, saved status, link register, program counter, handler flag and taken strobe all show the effect of the stimulus in the cycle right after the clock edge that samples it. The strobe falls one cycle later. The bench drives each stimulus 5 ns after a rising edge, waits for exactly one rising edge, and samples 5 ns after that edge, so each comparison looks at the first cycle in which the result can appear. The sweep covers every mix of request, boundary, both mask bits and the instruction-set bit under three mode values and three upper-bit patterns. Directed cases then cover the collision, override and nesting cases.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    // Status word field positions and mode codes
    localparam int          MODE_W   = 5;
    localparam int          BIT_T    = 5;
    localparam int          BIT_F    = 6;
    localparam int          BIT_I    = 7;
    localparam logic [4:0]  MODE_IRQ = 5'b10010;
    localparam logic [4:0]  MODE_SVC = 5'b10011;

    typedef enum logic {
        ST_THREAD  = 1'b0,
        ST_HANDLER = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2
    } seq_action_e;

endpackage

// File: rtl/irq_seq_accept.sv
module irq_seq_accept
    import irq_seq_pkg::*;
(
    input  logic        irq_req,
    input  logic        insn_boundary,
    input  logic        eret_cmd,
    input  logic        irq_masked,
    input  logic        in_handler,
    output seq_action_e action
);

    logic ret_ok;
    logic enter_ok;

    assign ret_ok   = eret_cmd && in_handler;
    assign enter_ok = irq_req && insn_boundary && !irq_masked;

    // A return always wins; the request stays pending outside the core
    always_comb begin
        if (ret_ok)
            action = ACT_RETURN;
        else if (enter_ok)
            action = ACT_ENTER;
        else
            action = ACT_NONE;
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  seq_action_e action,
    output logic        in_handler
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_THREAD;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_THREAD: begin
                if (action == ACT_ENTER)
                    state_d = ST_HANDLER;          // ENTER
            end
            ST_HANDLER: begin
                if (action == ACT_RETURN)
                    state_d = ST_THREAD;           // RETURN
                else if (action == ACT_ENTER)
                    state_d = ST_HANDLER;          // NEST
            end
            default: state_d = ST_THREAD;
        endcase
    end

    always_comb begin
        in_handler = (state_q == ST_HANDLER);
    end

endmodule

// File: rtl/irq_seq_arch.sv
module irq_seq_arch
    import irq_seq_pkg::*;
#(
    parameter int           XLEN   = 32,
    parameter logic [XLEN-1:0] VECTOR = 32'h0000_0018
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_action_e     action,
    input  logic            stat_we,
    input  logic [XLEN-1:0] stat_wdata,
    input  logic            pc_we,
    input  logic [XLEN-1:0] pc_wdata,
    input  logic [XLEN-1:0] eret_addr,
    output logic [XLEN-1:0] status,
    output logic [XLEN-1:0] saved,
    output logic [XLEN-1:0] link,
    output logic [XLEN-1:0] pc,
    output logic            taken
);

    localparam logic [XLEN-1:0] RESET_STATUS =
        {{(XLEN-8){1'b0}}, 1'b1, 1'b1, 1'b0, MODE_SVC};

    logic [XLEN-1:0] entry_status;

    always_comb begin
        entry_status               = status;
        entry_status[MODE_W-1:0]   = MODE_IRQ;
        entry_status[BIT_T]        = 1'b0;
        entry_status[BIT_F]        = 1'b1;
        entry_status[BIT_I]        = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= RESET_STATUS;
            saved  <= '0;
            link   <= '0;
            pc     <= '0;
            taken  <= 1'b0;
        end else begin
            taken <= (action == ACT_ENTER);
            unique case (action)
                ACT_ENTER: begin
                    saved  <= status;
                    status <= entry_status;
                    link   <= pc;
                    pc     <= VECTOR;
                end
                ACT_RETURN: begin
                    status <= saved;
                    pc     <= eret_addr;
                end
                default: begin
                    if (stat_we)
                        status <= stat_wdata;
                    if (pc_we)
                        pc <= pc_wdata;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int              XLEN   = 32,
    parameter logic [XLEN-1:0] VECTOR = 32'h0000_0018
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_req,
    input  logic            insn_boundary,
    input  logic            eret_cmd,
    input  logic [XLEN-1:0] eret_addr,
    input  logic            stat_we,
    input  logic [XLEN-1:0] stat_wdata,
    input  logic            pc_we,
    input  logic [XLEN-1:0] pc_wdata,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] saved_status_o,
    output logic [XLEN-1:0] link_o,
    output logic [XLEN-1:0] pc_o,
    output logic            taken_o,
    output logic            handler_active_o
);

    seq_action_e action;
    logic        in_handler;

    irq_seq_accept u_accept (
        .irq_req       (irq_req),
        .insn_boundary (insn_boundary),
        .eret_cmd      (eret_cmd),
        .irq_masked    (status_o[BIT_I]),
        .in_handler    (in_handler),
        .action        (action)
    );

    irq_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .action     (action),
        .in_handler (in_handler)
    );

    irq_seq_arch #(
        .XLEN   (XLEN),
        .VECTOR (VECTOR)
    ) u_arch (
        .clk        (clk),
        .rst_n      (rst_n),
        .action     (action),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .pc_we      (pc_we),
        .pc_wdata   (pc_wdata),
        .eret_addr  (eret_addr),
        .status     (status_o),
        .saved      (saved_status_o),
        .link       (link_o),
        .pc         (pc_o),
        .taken      (taken_o)
    );

    assign handler_active_o = in_handler;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int              XLEN   = 32,
    parameter logic [XLEN-1:0] VECTOR = 32'h0000_0018
) (
    input logic            clk,
    input logic            rst_n,
    input logic            eret_cmd,
    input logic [XLEN-1:0] eret_addr,
    input logic [XLEN-1:0] status_o,
    input logic [XLEN-1:0] saved_status_o,
    input logic [XLEN-1:0] link_o,
    input logic [XLEN-1:0] pc_o,
    input logic            taken_o,
    input logic            handler_active_o
);

    AST_TAKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> !taken_o);                                         // R2
    AST_TAKEN_IN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> handler_active_o);                                 // R2
    AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> saved_status_o == $past(status_o));                // R3
    AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (status_o[4:0] == 5'b10010) && status_o[7] && status_o[6] && !status_o[5]); // R4
    AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (pc_o == VECTOR) && (link_o == $past(pc_o)));      // R5
    AST_MASKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7] |=> !taken_o);                                     // R6
    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_active_o && eret_cmd) |=>
            !handler_active_o && !taken_o && (status_o == $past(saved_status_o)) && (pc_o == $past(eret_addr))); // R7

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .XLEN   (XLEN),
    .VECTOR (VECTOR)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .eret_cmd         (eret_cmd),
    .eret_addr        (eret_addr),
    .status_o         (status_o),
    .saved_status_o   (saved_status_o),
    .link_o           (link_o),
    .pc_o             (pc_o),
    .taken_o          (taken_o),
    .handler_active_o (handler_active_o)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        eret_cmd = 1'b0;
    logic [31:0] eret_addr = '0;
    logic        stat_we = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic        pc_we = 1'b0;
    logic [31:0] pc_wdata = '0;
    logic [31:0] status_o, saved_status_o, link_o, pc_o;
    logic        taken_o, handler_active_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_entry_seq u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .irq_req          (irq_req),
        .insn_boundary    (insn_boundary),
        .eret_cmd         (eret_cmd),
        .eret_addr        (eret_addr),
        .stat_we          (stat_we),
        .stat_wdata       (stat_wdata),
        .pc_we            (pc_we),
        .pc_wdata         (pc_wdata),
        .status_o         (status_o),
        .saved_status_o   (saved_status_o),
        .link_o           (link_o),
        .pc_o             (pc_o),
        .taken_o          (taken_o),
        .handler_active_o (handler_active_o)
    );

    function automatic logic [31:0] entered(input logic [31:0] s);
        return {s[31:8], 3'b110, 5'b10010};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        irq_req = 0; insn_boundary = 0; eret_cmd = 0;
        stat_we = 0; pc_we = 0;
    endtask

    // One edge, then sample 5 ns later
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #5;
        rst_n = 1;
    endtask

    task automatic preload(input logic [31:0] s, input logic [31:0] p);
        idle_inputs();
        stat_we = 1; stat_wdata = s;
        pc_we = 1;   pc_wdata = p;
        step();
        idle_inputs();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] s, p, h;
        do_reset();
        // R1 reset state
        chk("R1 status", status_o, 32'h0000_00D3);
        chk("R1 pc", pc_o, 0);
        chk("R1 saved", saved_status_o, 0);
        chk("R1 link", link_o, 0);
        chk("R1 taken", {31'b0, taken_o}, 0);
        chk("R1 active", {31'b0, handler_active_o}, 0);
        // R1 masked out of reset: request ignored (R6)
        irq_req = 1; insn_boundary = 1;
        step();
        chk("R6 reset-masked taken", {31'b0, taken_o}, 0);
        chk("R6 reset-masked pc", pc_o, 0);

        // Sweep: req, boundary, I, F, T x mode x upper bits
        for (int m = 0; m < 3; m++) begin
            for (int c = 0; c < 32; c++) begin
                logic [4:0] mode;
                logic acc;
                mode = (m == 0) ? 5'b10000 : (m == 1) ? 5'b11111 : 5'b10011;
                s = {32'hA5C3_0F00 ^ (32'(m) << 20)} & 32'hFFFF_FF00;
                s[7] = c[2]; s[6] = c[3]; s[5] = c[4]; s[4:0] = mode;
                p = 32'h0000_1000 + 32'(c) * 4 + 32'(m) * 256;
                acc = c[0] && c[1] && !c[2];
                do_reset();
                preload(s, p);
                chk("R10 status write", status_o, s);
                irq_req = c[0]; insn_boundary = c[1];
                step();
                idle_inputs();
                if (acc) begin
                    chk("R2 taken", {31'b0, taken_o}, 1);
                    chk("R2 active", {31'b0, handler_active_o}, 1);
                    chk("R3 saved", saved_status_o, s);
                    chk("R4 status", status_o, entered(s));
                    chk("R5 link", link_o, p);
                    chk("R5 pc", pc_o, 32'h18);
                    step();
                    chk("R2 pulse end", {31'b0, taken_o}, 0);
                    eret_cmd = 1; eret_addr = p + 4;
                    step();
                    idle_inputs();
                    chk("R7 status", status_o, s);
                    chk("R7 pc", pc_o, p + 4);
                    chk("R7 active", {31'b0, handler_active_o}, 0);
                end else begin
                    chk("R6 taken", {31'b0, taken_o}, 0);
                    chk("R6 status", status_o, s);
                    chk("R6 pc", pc_o, p);
                    chk("R6 link", link_o, 0);
                    chk("R6 saved", saved_status_o, 0);
                    eret_cmd = 1; eret_addr = 32'hDEAD_0000;
                    step();
                    idle_inputs();
                    chk("R8 status", status_o, s);
                    chk("R8 pc", pc_o, p);
                    chk("R8 active", {31'b0, handler_active_o}, 0);
                end
            end
        end

        // R9: return and acceptable request together
        do_reset();
        s = 32'h1234_5610;
        preload(s, 32'h0000_2000);
        irq_req = 1; insn_boundary = 1;
        step();
        idle_inputs();
        h = 32'h0000_0052;                 // handler status, I clear
        preload(h, 32'h0000_0100);
        irq_req = 1; insn_boundary = 1; eret_cmd = 1; eret_addr = 32'h0000_2004;
        step();
        idle_inputs();
        chk("R9 taken", {31'b0, taken_o}, 0);
        chk("R9 status", status_o, s);
        chk("R9 pc", pc_o, 32'h0000_2004);
        chk("R9 active", {31'b0, handler_active_o}, 0);

        // R10: entry overrides same-cycle writes
        do_reset();
        s = 32'h0000_0030;
        preload(s, 32'h0000_3000);
        irq_req = 1; insn_boundary = 1;
        stat_we = 1; stat_wdata = 32'hFFFF_FFFF;
        pc_we = 1; pc_wdata = 32'h0000_7777;
        step();
        idle_inputs();
        chk("R10 override status", status_o, entered(s));
        chk("R10 override pc", pc_o, 32'h18);
        chk("R10 override saved", saved_status_o, s);

        // R11: nested acceptance
        h = 32'h0000_0012;                 // IRQ mode, I clear
        preload(h, 32'h0000_0040);
        irq_req = 1; insn_boundary = 1;
        step();
        idle_inputs();
        chk("R11 taken", {31'b0, taken_o}, 1);
        chk("R11 saved", saved_status_o, h);
        chk("R11 link", link_o, 32'h0000_0040);
        chk("R11 active", {31'b0, handler_active_o}, 1);
        chk("R11 status", status_o, entered(h));

        summary();
        $finish;
    end

endmodule